// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes Ethernet frames from a byte-stream source and deposits them into a circular packet memory. The memory is divided into 256-byte pages. The ring is bounded by a first page and an end page; the end page is exclusive and is never written. The block owns the current-page pointer, which marks where the next frame goes. The host owns a boundary pointer, which marks how far it has consumed the ring.

A frame starts with a start request that carries its length. The block grants the request only when it is running and when the ring has room for a maximum-size frame. Once granted, it takes frame bytes one per clock and writes each to RAM, wrapping from the end page back to the first page. Short frames are filled out with zeros. Last of all it writes a four-byte header at the base of the frame's first page. The header holds a status byte, a link to the next free page, and the stored length. The block then moves the current-page pointer to that link and raises a sticky receive flag.

Top module: `rxring_writer`

## Requirements
- R1: Data bytes go to consecutive addresses. When an address would step onto the first byte of the end page, it continues at the first byte of the first page, so no byte is ever written at or above the end page.
- R2: Free space in bytes is (boundary − current)·256 when current < boundary. Otherwise it is (end − first)·256 − (current − boundary)·256, so equal pointers mean the whole ring is free.
- R3: `sof_ready` is high only in the idle state, with `stop_cmd` low and free space of at least 1518 bytes. A refused frame causes no RAM write and leaves `cur_pg` unchanged.
- R4: A frame shorter than 60 bytes, including a zero-length frame, has zero bytes appended so that exactly 60 data bytes are stored.
- R5: The header occupies offsets 0..3 of the page that was current when the frame was accepted. Its bytes are, in order: the status byte, the next page, the stored-length low byte, and the stored-length high byte.
- R6: The stored length is the padded frame length plus 4.
- R7: The next page is current + ceil((stored length + 4)/256). If this is at or above the end page, (end − first) is subtracted.
- R8: The status byte is 0x01. It is 0x21 when bit 0 of the first frame byte is 1, which covers multicast and broadcast.
- R9: On the clock that writes the last header byte, `cur_pg` takes the next page and `rx_flag` is set. `rx_flag_clr` clears the flag, but setting wins when both happen together.
- R10: Exactly one RAM byte is written per clock. Data byte k of the frame lands at current·256 + 4 + k before any wrap, and a frame performs padded length + 4 writes in total.
- R11: After reset, `cur_pg` is 0, `rx_flag` is 0 and no write is issued. A `cur_wr` pulse loads `cur_wdata` into `cur_pg` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_cmd | input | 1 | Receiver stopped; new frames are refused |
| ring_first_pg | input | 8 | First page of the ring |
| ring_end_pg | input | 8 | Page one past the last ring page |
| host_bnd_pg | input | 8 | Host-owned boundary page |
| cur_wr | input | 1 | Host load strobe for the current page |
| cur_wdata | input | 8 | Value loaded by `cur_wr` |
| rx_flag_clr | input | 1 | Clears the receive flag |
| sof_valid | input | 1 | Frame start request |
| sof_len | input | 11 | Frame length in bytes (0..1514) |
| sof_ready | output | 1 | Start request granted |
| byte_valid | input | 1 | Frame byte present |
| byte_data | input | 8 | Frame byte |
| byte_ready | output | 1 | Block takes a frame byte this clock |
| mem_we | output | 1 | Packet RAM write strobe |
| mem_addr | output | 16 | Packet RAM byte address |
| mem_wdata | output | 8 | Packet RAM write data |
| cur_pg | output | 8 | Current page pointer |
| rx_flag | output | 1 | Sticky receive flag |

## Verification
The hardest situations to reach are a frame that crosses the end page and a next-page link that lands exactly on the end page and must fold back to the first page. Both depend on a specific combination of ring bounds, starting page and length. The stimulus table sets these up directly by loading the current page through the host strobe before each frame. It also places the free-space result exactly at 1536 and at 1280 bytes, which brackets the 1518-byte threshold. A RAM model in the bench tags every write with the vector that made it. This lets the bench prove that padding bytes were actually written as zeros, and that refused frames wrote nothing.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int PAGE_OFS_W = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_PAD  = 2'd2,
        S_HDR  = 2'd3
    } rx_st_e;
endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
    parameter int PG_W  = 8,
    parameter int OFS_W = 8,
    parameter int NEED  = 1518
) (
    input  logic [PG_W-1:0] first_pg,
    input  logic [PG_W-1:0] end_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            room_ok
);
    localparam int AV_W = PG_W + 1 + OFS_W;

    logic [PG_W:0] ring_pg;
    logic [PG_W:0] ahead_pg;
    logic [PG_W:0] avail_pg;

    always_comb begin
        ring_pg  = {1'b0, end_pg} - {1'b0, first_pg};
        ahead_pg = {1'b0, cur_pg} - {1'b0, bnd_pg};
        if (cur_pg < bnd_pg)
            avail_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
        else
            avail_pg = ring_pg - ahead_pg;
        room_ok = ({avail_pg, {OFS_W{1'b0}}} >= AV_W'(NEED));
    end
endmodule

// File: rtl/rxring_nextpg.sv
module rxring_nextpg #(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 11,
    parameter int OFS_W     = 8,
    parameter int CRC_BYTES = 4
) (
    input  logic [PG_W-1:0]  cur_pg,
    input  logic [PG_W-1:0]  first_pg,
    input  logic [PG_W-1:0]  end_pg,
    input  logic [LEN_W-1:0] tot_len,
    output logic [PG_W-1:0]  next_pg
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] rounded;
    logic [PG_W:0]    raw;
    logic [PG_W:0]    folded;

    always_comb begin
        rounded = {1'b0, tot_len} + SUM_W'(CRC_BYTES + (1 << OFS_W) - 1);
        raw     = {1'b0, cur_pg} + (PG_W+1)'(rounded >> OFS_W);
        if (raw >= {1'b0, end_pg})
            folded = raw - ({1'b0, end_pg} - {1'b0, first_pg});
        else
            folded = raw;
        next_pg = folded[PG_W-1:0];
    end
endmodule

// File: rtl/rxring_addr_step.sv
module rxring_addr_step #(
    parameter int PG_W  = 8,
    parameter int OFS_W = 8
) (
    input  logic [PG_W+OFS_W-1:0] addr,
    input  logic [PG_W-1:0]       first_pg,
    input  logic [PG_W-1:0]       end_pg,
    output logic [PG_W+OFS_W-1:0] addr_nxt
);
    logic [PG_W+OFS_W-1:0] inc;

    always_comb begin
        inc = addr + 1'b1;
        if (inc == {end_pg, {OFS_W{1'b0}}})
            addr_nxt = {first_pg, {OFS_W{1'b0}}};
        else
            addr_nxt = inc;
    end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    parameter int HDR_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stop_cmd,
    input  logic [PG_W-1:0]          ring_first_pg,
    input  logic [PG_W-1:0]          ring_end_pg,
    input  logic [PG_W-1:0]          host_bnd_pg,
    input  logic                     cur_wr,
    input  logic [PG_W-1:0]          cur_wdata,
    input  logic                     rx_flag_clr,
    input  logic                     sof_valid,
    input  logic [LEN_W-1:0]         sof_len,
    output logic                     sof_ready,
    input  logic                     byte_valid,
    input  logic [7:0]               byte_data,
    output logic                     byte_ready,
    output logic                     mem_we,
    output logic [PG_W+PAGE_OFS_W-1:0] mem_addr,
    output logic [7:0]               mem_wdata,
    output logic [PG_W-1:0]          cur_pg,
    output logic                     rx_flag
);
    localparam int OFS_W  = PAGE_OFS_W;
    localparam int ADDR_W = PG_W + OFS_W;
    localparam int HIDX_W = $clog2(HDR_BYTES);
    localparam int NEED   = MAX_FRAME + HDR_BYTES;

    typedef struct packed {
        rx_st_e              st;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    cnt;
        logic [LEN_W-1:0]    len;
        logic [LEN_W-1:0]    tot;
        logic [PG_W-1:0]     nxt;
        logic [PG_W-1:0]     base;
        logic                mc;
        logic [HIDX_W-1:0]   hidx;
        logic                we;
        logic [ADDR_W-1:0]   waddr;
        logic [7:0]          wdata;
        logic [PG_W-1:0]     cur;
        logic                flag;
    } wr_state_t;

    wr_state_t st_d, st_q;

    logic              room_ok;
    logic [LEN_W-1:0]  pad_len_w;
    logic [LEN_W-1:0]  tot_w;
    logic [PG_W-1:0]   nxt_w;
    logic [ADDR_W-1:0] addr_step_w;

    assign pad_len_w = (sof_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : sof_len;
    assign tot_w     = pad_len_w + LEN_W'(HDR_BYTES);

    rxring_space #(.PG_W(PG_W), .OFS_W(OFS_W), .NEED(NEED)) u_space (
        .first_pg (ring_first_pg),
        .end_pg   (ring_end_pg),
        .bnd_pg   (host_bnd_pg),
        .cur_pg   (st_q.cur),
        .room_ok  (room_ok)
    );

    rxring_nextpg #(.PG_W(PG_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .CRC_BYTES(4)) u_nextpg (
        .cur_pg   (st_q.cur),
        .first_pg (ring_first_pg),
        .end_pg   (ring_end_pg),
        .tot_len  (tot_w),
        .next_pg  (nxt_w)
    );

    rxring_addr_step #(.PG_W(PG_W), .OFS_W(OFS_W)) u_step (
        .addr     (st_q.addr),
        .first_pg (ring_first_pg),
        .end_pg   (ring_end_pg),
        .addr_nxt (addr_step_w)
    );

    assign sof_ready  = (st_q.st == S_IDLE) && !stop_cmd && room_ok;
    assign byte_ready = (st_q.st == S_DATA);

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (rx_flag_clr) st_d.flag = 1'b0;
        if (cur_wr)      st_d.cur  = cur_wdata;
        unique case (st_q.st)
            S_IDLE: begin
                if (sof_valid && sof_ready) begin
                    st_d.len  = sof_len;
                    st_d.tot  = tot_w;
                    st_d.nxt  = nxt_w;
                    st_d.base = st_q.cur;
                    st_d.addr = {st_q.cur, {OFS_W{1'b0}}} + ADDR_W'(HDR_BYTES);
                    st_d.cnt  = '0;
                    st_d.mc   = 1'b0;
                    st_d.st   = (sof_len == '0) ? S_PAD : S_DATA;
                end
            end
            S_DATA: begin
                if (byte_valid) begin
                    st_d.we    = 1'b1;
                    st_d.waddr = st_q.addr;
                    st_d.wdata = byte_data;
                    st_d.addr  = addr_step_w;
                    st_d.cnt   = st_q.cnt + 1'b1;
                    if (st_q.cnt == '0) st_d.mc = byte_data[0];
                    if ((st_q.cnt + 1'b1) == st_q.len) begin
                        st_d.st   = (st_q.len < LEN_W'(MIN_FRAME)) ? S_PAD : S_HDR;
                        st_d.hidx = '0;
                    end
                end
            end
            S_PAD: begin
                st_d.we    = 1'b1;
                st_d.waddr = st_q.addr;
                st_d.wdata = 8'h00;
                st_d.addr  = addr_step_w;
                st_d.cnt   = st_q.cnt + 1'b1;
                if ((st_q.cnt + 1'b1) >= LEN_W'(MIN_FRAME)) begin
                    st_d.st   = S_HDR;
                    st_d.hidx = '0;
                end
            end
            S_HDR: begin
                st_d.we    = 1'b1;
                st_d.waddr = {st_q.base, {OFS_W{1'b0}}} + ADDR_W'(st_q.hidx);
                case (st_q.hidx)
                    HIDX_W'(0): st_d.wdata = 8'h01 | {2'b00, st_q.mc, 5'b00000};
                    HIDX_W'(1): st_d.wdata = 8'(st_q.nxt);
                    HIDX_W'(2): st_d.wdata = st_q.tot[7:0];
                    default:    st_d.wdata = 8'(st_q.tot >> 8);
                endcase
                st_d.hidx = st_q.hidx + 1'b1;
                if (st_q.hidx == HIDX_W'(HDR_BYTES - 1)) begin
                    st_d.cur  = st_q.nxt;
                    st_d.flag = 1'b1;
                    st_d.st   = S_IDLE;
                end
            end
            default: st_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.waddr;
    assign mem_wdata = st_q.wdata;
    assign cur_pg    = st_q.cur;
    assign rx_flag   = st_q.flag;
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk #(
    parameter int PG_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stop_cmd,
    input logic [PG_W-1:0]      ring_first_pg,
    input logic [PG_W-1:0]      ring_end_pg,
    input logic                 cur_wr,
    input logic                 sof_ready,
    input logic                 byte_ready,
    input logic                 mem_we,
    input logic [PG_W+7:0]      mem_addr,
    input logic [PG_W-1:0]      cur_pg,
    input logic                 rx_flag
);
    AST_NO_GRANT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |-> !sof_ready); // R3

    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_ready && byte_ready)); // R10

    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {ring_first_pg, 8'h00}) && (mem_addr < {ring_end_pg, 8'h00})); // R1

    AST_CUR_MOVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_pg) && !$past(cur_wr)) |-> rx_flag); // R9

    AST_FLAG_WITH_HDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> mem_we); // R9
endmodule

bind rxring_writer rxring_writer_chk #(.PG_W(PG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_cmd      (stop_cmd),
    .ring_first_pg (ring_first_pg),
    .ring_end_pg   (ring_end_pg),
    .cur_wr        (cur_wr),
    .sof_ready     (sof_ready),
    .byte_ready    (byte_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .cur_pg        (cur_pg),
    .rx_flag       (rx_flag)
);

// File: tb/rxring_writer_bench.sv
module rxring_writer_bench;
    localparam int NVEC = 10;
    localparam int RAM_SZ = 4096;
    // columns: first page, end page, boundary, current, length, first byte
    localparam int VEC [NVEC][6] = '{
        '{1, 16, 1, 1, 100,  'h02},
        '{1, 16, 1, 2, 40,   'h01},
        '{1, 8,  6, 6, 600,  'h00},
        '{1, 16, 5, 3, 100,  'h00},
        '{1, 16, 8, 2, 1514, 'h04},
        '{1, 16, 7, 2, 100,  'h00},
        '{1, 16, 1, 10, 60,  'hFF},
        '{2, 10, 9, 9, 248,  'h10},
        '{1, 8,  7, 7, 1514, 'h03},
        '{1, 16, 1, 3, 1,    'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_cmd = 1'b0;
    logic [7:0]  ring_first_pg = 8'd1;
    logic [7:0]  ring_end_pg = 8'd16;
    logic [7:0]  host_bnd_pg = 8'd1;
    logic        cur_wr = 1'b0;
    logic [7:0]  cur_wdata = 8'd0;
    logic        rx_flag_clr = 1'b0;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_len = 11'd0;
    logic        sof_ready;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'd0;
    logic        byte_ready;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        rx_flag;

    int checks = 0;
    int fails = 0;
    int tag = 0;
    int wr_cnt = 0;
    bit done = 1'b0;
    logic [7:0] ram  [RAM_SZ];
    int         mark [RAM_SZ];

    always #2 clk = ~clk;

    rxring_writer u_rxring_writer (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd),
        .ring_first_pg(ring_first_pg), .ring_end_pg(ring_end_pg), .host_bnd_pg(host_bnd_pg),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata), .rx_flag_clr(rx_flag_clr),
        .sof_valid(sof_valid), .sof_len(sof_len), .sof_ready(sof_ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .rx_flag(rx_flag)
    );

    always_ff @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr[11:0]]  <= mem_wdata;
            mark[mem_addr[11:0]] <= tag;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int dbyte(input int k, input int v, input int b0);
        return (k == 0) ? b0 : ((k * 7 + v * 13 + 1) & 'hFF);
    endfunction

    task automatic setup(input int s, input int e, input int b, input int c);
        @(negedge clk);
        ring_first_pg = 8'(s);
        ring_end_pg   = 8'(e);
        host_bnd_pg   = 8'(b);
        cur_wr        = 1'b1;
        cur_wdata     = 8'(c);
        rx_flag_clr   = 1'b1;
        @(negedge clk);
        cur_wr      = 1'b0;
        rx_flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(cur_pg == 8'd0, "R11 reset cur_pg", int'(cur_pg), 0);
        chk(rx_flag == 1'b0, "R11 reset rx_flag", int'(rx_flag), 0);
        chk(mem_we == 1'b0, "R11 reset mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_ready == 1'b0, "R11 idle byte_ready", int'(byte_ready), 0);

        for (int v = 0; v < NVEC; v++) begin
            int s, e, b, c, l, b0, avail, padl, tot, np, wr0, a, base;
            bit acc, seen, ok;
            s = VEC[v][0]; e = VEC[v][1]; b = VEC[v][2];
            c = VEC[v][3]; l = VEC[v][4]; b0 = VEC[v][5];
            tag = v + 1;
            setup(s, e, b, c);
            // R11: host load of current page
            chk(cur_pg == 8'(c), "R11 cur load", int'(cur_pg), c);
            // R2: free space; R3: threshold
            if (c < b) avail = (b - c) * 256;
            else       avail = (e - s) * 256 - (c - b) * 256;
            acc  = (avail >= 1518);
            padl = (l < 60) ? 60 : l;
            tot  = padl + 4;
            np   = c + (tot + 4 + 255) / 256;
            if (np >= e) np -= (e - s);
            wr0  = wr_cnt;
            sof_valid = 1'b1;
            sof_len   = 11'(l);
            #1;
            if (!acc) begin
                seen = 1'b0;
                for (int t = 0; t < 10; t++) begin
                    if (sof_ready) seen = 1'b1;
                    @(negedge clk);
                end
                sof_valid = 1'b0;
                repeat (2) @(negedge clk);
                chk(!seen, "R2 R3 refused grant", int'(seen), 0);
                chk(cur_pg == 8'(c), "R3 refused cur_pg", int'(cur_pg), c);
                chk(wr_cnt == wr0, "R3 refused writes", wr_cnt - wr0, 0);
            end else begin
                chk(sof_ready == 1'b1, "R2 R3 grant", int'(sof_ready), 1);
                @(negedge clk);
                sof_valid = 1'b0;
                for (int k = 0; k < l; k++) begin
                    byte_valid = 1'b1;
                    byte_data  = 8'(dbyte(k, v, b0));
                    #1;
                    while (!byte_ready) @(negedge clk);
                    @(negedge clk);
                end
                byte_valid = 1'b0;
                for (int t = 0; t < 200 && !rx_flag; t++) @(negedge clk);
                repeat (2) @(negedge clk);
                base = c * 256;
                chk(ram[base] == 8'(((b0 & 1) != 0) ? 'h21 : 'h01), "R5 R8 status byte",
                    int'(ram[base]), ((b0 & 1) != 0) ? 'h21 : 'h01);
                chk(ram[base+1] == 8'(np), "R5 R7 next page", int'(ram[base+1]), np);
                chk(ram[base+2] == 8'(tot & 'hFF), "R5 R6 length low", int'(ram[base+2]), tot & 'hFF);
                chk(ram[base+3] == 8'(tot >> 8), "R5 R6 length high", int'(ram[base+3]), tot >> 8);
                ok = 1'b1;
                for (int k = 0; k < padl; k++) begin
                    a = base + 4 + k;
                    if (a >= e * 256) a -= (e - s) * 256;
                    if (k < l) begin
                        if (ram[a] != 8'(dbyte(k, v, b0)) || mark[a] != tag) ok = 1'b0;
                    end else begin
                        if (ram[a] != 8'h00 || mark[a] != tag) ok = 1'b0;
                    end
                end
                chk(ok, "R1 R4 R10 data and pad placement", int'(ok), 1);
                chk(wr_cnt - wr0 == padl + 4, "R10 write count", wr_cnt - wr0, padl + 4);
                chk(cur_pg == 8'(np), "R7 R9 cur advanced", int'(cur_pg), np);
                chk(rx_flag == 1'b1, "R9 rx_flag set", int'(rx_flag), 1);
            end
        end

        // R9: flag clear
        @(negedge clk);
        rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        chk(rx_flag == 1'b0, "R9 rx_flag clear", int'(rx_flag), 0);

        // R3: stop command refuses even with room
        setup(1, 16, 1, 1);
        stop_cmd  = 1'b1;
        sof_valid = 1'b1;
        sof_len   = 11'd100;
        begin
            int wr0;
            bit seen;
            wr0 = wr_cnt;
            seen = 1'b0;
            #1;
            for (int t = 0; t < 8; t++) begin
                if (sof_ready) seen = 1'b1;
                @(negedge clk);
            end
            sof_valid = 1'b0;
            stop_cmd  = 1'b0;
            #1;
            chk(!seen, "R3 stopped grant", int'(seen), 0);
            chk(wr_cnt == wr0 && cur_pg == 8'd1, "R3 stopped no effect", wr_cnt - wr0, 0);
            chk(sof_ready == 1'b1, "R3 ready after restart", int'(sof_ready), 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule